// File: doc/BRIEF.md
# Processing-Element Wake and Quiescence Controller

This block sits between the interrupt router and a single processing element (PE). It tracks whether that PE is online or asleep. It holds the interrupts routed to the PE and decides whether they may be delivered. It also runs the handshake with the PE's external power controller.

Software controls the block through two bits:

- **Processor-sleep bit (writable).** Writing 1 marks the PE offline. Writing 0 starts the move back online.
- **Children-asleep status bit (read-only).** Software polls this bit after clearing processor-sleep. It stays 1 until the power controller reports that the PE-side interface is ready.

While the PE is marked asleep, the interrupt request to the PE is forced low. Any interrupt that arrives is kept pending. The block raises a wake request to the power controller. Once powered, the PE clears processor-sleep itself, and that write retires the wake request.

Going to sleep is a drain. After processor-sleep is set, children-asleep rises only when both of these hold:

- Every interrupt the PE has acknowledged has been completed.
- A minimum quiescence delay has elapsed.

Interrupt sources are numbered 0 to N_SRC-1 and arrive as one-cycle event pulses. The lowest-numbered pending source is presented to the PE first (the default ordering). An acknowledge moves the presented source from pending to active. An end-of-interrupt carrying a source number returns that source to inactive.

Top module: `rdist_wake_ctrl`

## Requirements
- R1: After reset, the processor-sleep bit and the children-asleep bit both read 1, the wake request is 0 and the PE interrupt request is 0.
- R2: A write with `reg_wr_en` high loads `reg_wr_sleep` into the processor-sleep bit, which reads back the new value from the next cycle on.
- R3: After processor-sleep reads 0, children-asleep stays 1 until `pwr_if_ready_i` has been sampled high in the waking phase; it then reads 0 from the following cycle.
- R4: After processor-sleep reads 1, children-asleep rises only once no acknowledged source is still active. It rises no earlier than MIN_QUIESCE+1 cycles (3 with the default MIN_QUIESCE of 2) after the bit first reads 1.
- R5: While processor-sleep reads 1, any source event or any already-pending source sets the wake request from the next cycle. The request then holds until a write of 0 to processor-sleep, and it drops in the same cycle that the bit reads 0.
- R6: While processor-sleep or children-asleep reads 1, `pe_irq_o` is 0 and no pending source is lost; sources pending before sleep are delivered after wake.
- R7: A pulse on `src_evt_i[k]` makes source k pending from the next cycle. `pe_irq_o` is 1 when the PE is online and any source is pending, and `pe_irq_id_o` then gives the lowest-numbered pending source.
- R8: `pe_ack_i` high while `pe_irq_o` is 1 clears the presented source's pending bit and marks it active. `pe_eoi_i` with `pe_eoi_id_i` = k clears source k's active state.
- R9: If an acknowledge of source k and a new event on source k fall in the same cycle, source k stays pending.
- R10: If processor-sleep is set and then cleared again before children-asleep has risen, children-asleep stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sleep | input | 1 | Value written to the processor-sleep bit |
| reg_sleep_o | output | 1 | Processor-sleep bit read value |
| reg_child_asleep_o | output | 1 | Children-asleep status read value |
| src_evt_i | input | N_SRC | One-cycle interrupt events per source |
| pe_irq_o | output | 1 | Interrupt request to the PE |
| pe_irq_id_o | output | IDW | Source number presented to the PE |
| pe_ack_i | input | 1 | PE acknowledges the presented source |
| pe_eoi_i | input | 1 | PE signals end of interrupt |
| pe_eoi_id_i | input | IDW | Source number being completed |
| pwr_wake_req_o | output | 1 | Wake request to the power controller |
| pwr_if_ready_i | input | 1 | Power controller reports PE interface ready |

## Verification
Several rules are checked by assertions on every cycle:

- Delivery is gated while asleep.
- Pending bits are never dropped while asleep.
- The wake request persists and implies processor-sleep.
- Children-asleep only rises after an idle, sleeping cycle.
- Children-asleep only falls after the ready input was seen.
- The presented source number always names a pending source.

Other properties can only be shown by the bench's scenarios:

- The exact quiescence delay.
- Presentation order among several pending sources.
- Survival of a pending source across a full sleep and wake.
- The collision of an acknowledge with a new event.
- An aborted drain.

// File: rtl/wake_pkg.sv
package wake_pkg;

   typedef enum logic [1:0] {
      PS_ONLINE = 2'd0,
      PS_DRAIN  = 2'd1,
      PS_ASLEEP = 2'd2,
      PS_WAKING = 2'd3
   } pwr_state_t;

   function automatic logic state_is_quiet(input pwr_state_t s);
      return (s == PS_ASLEEP) || (s == PS_WAKING);
   endfunction

endpackage

// File: rtl/wake_src_bank.sv
module wake_src_bank #(
   parameter int N_SRC = 8,
   parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             ack_fire_i,
   input  logic [IDW-1:0]   ack_id_i,
   input  logic             eoi_fire_i,
   input  logic [IDW-1:0]   eoi_id_i,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] act_o
);

   initial begin
      if (N_SRC < 2 || N_SRC > 64)
         $error("wake_src_bank: N_SRC out of range");
      if ((1 << IDW) < N_SRC)
         $error("wake_src_bank: IDW too narrow");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic ack_hit;
      logic eoi_hit;

      assign ack_hit = ack_fire_i && (ack_id_i == IDW'(i));
      assign eoi_hit = eoi_fire_i && (eoi_id_i == IDW'(i));

      // A new event beats a simultaneous acknowledge of the same source.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[i] <= 1'b0;
         else if (evt_i[i])
            pend_o[i] <= 1'b1;
         else if (ack_hit)
            pend_o[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_o[i] <= 1'b0;
         else if (ack_hit)
            act_o[i] <= 1'b1;
         else if (eoi_hit)
            act_o[i] <= 1'b0;
      end

      AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         ack_hit |-> pend_o[i]); // R8
      AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[i] && ack_hit) |=> pend_o[i]); // R9
   end

endmodule

// File: rtl/wake_pick.sv
module wake_pick #(
   parameter int N_SRC     = 8,
   parameter int IDW       = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_SRC-1:0] pend_i,
   output logic             any_o,
   output logic [IDW-1:0]   id_o
);

   assign any_o = |pend_i;

   if (LOW_FIRST) begin : g_low
      // Scan downward so the lowest set index is the last one written.
      always_comb begin
         id_o = '0;
         for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) id_o = IDW'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         id_o = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i]) id_o = IDW'(i);
         end
      end
   end

endmodule

// File: rtl/wake_pwr_seq.sv
module wake_pwr_seq
   import wake_pkg::*;
#(
   parameter int MIN_QUIESCE = 2,
   parameter int CW          = $clog2(MIN_QUIESCE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic idle_i,
   input  logic if_ready_i,
   output logic child_o
);

   initial begin
      if (MIN_QUIESCE < 2)
         $error("wake_pwr_seq: MIN_QUIESCE must be at least 2");
   end

   localparam logic [CW-1:0] CNT_LAST = CW'(MIN_QUIESCE - 1);

   pwr_state_t st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         PS_ONLINE: begin
            if (sleep_i) begin
               st_d  = PS_DRAIN;
               cnt_d = '0;
            end
         end
         PS_DRAIN: begin
            if (!sleep_i)
               st_d = PS_ONLINE;
            else if (cnt_q != CNT_LAST)
               cnt_d = cnt_q + CW'(1);
            else if (idle_i)
               st_d = PS_ASLEEP;
         end
         PS_ASLEEP: begin
            if (!sleep_i) st_d = PS_WAKING;
         end
         PS_WAKING: begin
            if (sleep_i)
               st_d = PS_ASLEEP;
            else if (if_ready_i)
               st_d = PS_ONLINE;
         end
         default: st_d = PS_ASLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_ASLEEP;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign child_o = state_is_quiet(st_q);

   AST_QUIESCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(child_o) |-> ($past(idle_i) && $past(sleep_i))); // R4
   AST_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(child_o) |-> ($past(if_ready_i) && !$past(sleep_i))); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST); // R4

endmodule

// File: rtl/rdist_wake_ctrl.sv
module rdist_wake_ctrl #(
   parameter int N_SRC       = 8,
   parameter int IDW         = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   parameter int MIN_QUIESCE = 2,
   parameter bit LOW_FIRST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic             reg_wr_sleep,
   output logic             reg_sleep_o,
   output logic             reg_child_asleep_o,
   input  logic [N_SRC-1:0] src_evt_i,
   output logic             pe_irq_o,
   output logic [IDW-1:0]   pe_irq_id_o,
   input  logic             pe_ack_i,
   input  logic             pe_eoi_i,
   input  logic [IDW-1:0]   pe_eoi_id_i,
   output logic             pwr_wake_req_o,
   input  logic             pwr_if_ready_i
);

   logic             sleep_q;
   logic             wake_q;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] act;
   logic             any_pend;
   logic [IDW-1:0]   pick_id;
   logic             child;
   logic             ack_fire;
   logic             clr_wr;

   // Processor-sleep bit, reset to offline.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sleep_q <= 1'b1;
      else if (reg_wr_en)
         sleep_q <= reg_wr_sleep;
   end

   assign clr_wr = reg_wr_en && !reg_wr_sleep;

   // Wake request: the clearing write wins over a new targeting event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wake_q <= 1'b0;
      else if (clr_wr)
         wake_q <= 1'b0;
      else if (sleep_q && ((|src_evt_i) || any_pend))
         wake_q <= 1'b1;
   end

   assign pe_irq_o = any_pend && !sleep_q && !child;
   assign ack_fire = pe_ack_i && pe_irq_o;

   wake_src_bank #(.N_SRC(N_SRC), .IDW(IDW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (src_evt_i),
      .ack_fire_i (ack_fire),
      .ack_id_i   (pick_id),
      .eoi_fire_i (pe_eoi_i),
      .eoi_id_i   (pe_eoi_id_i),
      .pend_o     (pend),
      .act_o      (act)
   );

   wake_pick #(.N_SRC(N_SRC), .IDW(IDW), .LOW_FIRST(LOW_FIRST)) u_pick (
      .pend_i (pend),
      .any_o  (any_pend),
      .id_o   (pick_id)
   );

   wake_pwr_seq #(.MIN_QUIESCE(MIN_QUIESCE)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_i    (sleep_q),
      .idle_i     (act == '0),
      .if_ready_i (pwr_if_ready_i),
      .child_o    (child)
   );

   assign reg_sleep_o        = sleep_q;
   assign reg_child_asleep_o = child;
   assign pe_irq_id_o        = pick_id;
   assign pwr_wake_req_o     = wake_q;

   AST_NO_DLV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reg_child_asleep_o |-> !pe_irq_o); // R6
   AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sleep_o |=> (($past(pend) & ~pend) == '0)); // R6
   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_wake_req_o && !(reg_wr_en && !reg_wr_sleep)) |=> pwr_wake_req_o); // R5
   AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_wake_req_o |-> reg_sleep_o); // R5
   AST_ID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pe_irq_o |-> pend[pe_irq_id_o]); // R7
   AST_SLEEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> (reg_sleep_o == $past(reg_wr_sleep))); // R2

endmodule

// File: tb/sim_rdist_wake_ctrl.sv
`timescale 1ns/1ps
module sim_rdist_wake_ctrl;

   localparam int N   = 8;
   localparam int IDW = 3;
   localparam int MQ  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sleep = 1'b0;
   logic [N-1:0] src = '0;
   logic ack = 1'b0, eoi = 1'b0;
   logic [IDW-1:0] eoi_id = '0;
   logic ready = 1'b0;
   logic sleep_o, child_o, irq_o, wake_o;
   logic [IDW-1:0] id_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string tag = "R1";

   always #10 clk = ~clk;

   rdist_wake_ctrl #(.N_SRC(N), .IDW(IDW), .MIN_QUIESCE(MQ)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(wr_en), .reg_wr_sleep(wr_sleep),
      .reg_sleep_o(sleep_o), .reg_child_asleep_o(child_o),
      .src_evt_i(src), .pe_irq_o(irq_o), .pe_irq_id_o(id_o),
      .pe_ack_i(ack), .pe_eoi_i(eoi), .pe_eoi_id_i(eoi_id),
      .pwr_wake_req_o(wake_o), .pwr_if_ready_i(ready)
   );

   // Behavioural reference: 0 online, 1 drain, 2 asleep, 3 waking.
   int m_sleep, m_child, m_wake, m_mode, m_cnt;
   int m_pend[N];
   int m_act[N];

   function automatic int m_lowest();
      for (int k = 0; k < N; k++) if (m_pend[k] != 0) return k;
      return -1;
   endfunction

   function automatic int m_irq();
      return (m_sleep == 0 && m_child == 0 && m_lowest() >= 0) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sleep = 1; m_child = 1; m_wake = 0; m_mode = 2; m_cnt = 0;
         for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_act[k] = 0; end
      end else begin
         int low, any_act, nmode;
         low = m_lowest();
         any_act = 0;
         for (int k = 0; k < N; k++) if (m_act[k] != 0) any_act = 1;
         nmode = m_mode;
         case (m_mode)
            0: if (m_sleep == 1) begin nmode = 1; m_cnt = 0; end
            1: if (m_sleep == 0) nmode = 0;
               else if (m_cnt < MQ - 1) m_cnt++;
               else if (any_act == 0) nmode = 2;
            2: if (m_sleep == 0) nmode = 3;
            default: if (m_sleep == 1) nmode = 2; else if (ready) nmode = 0;
         endcase
         if (wr_en && !wr_sleep) m_wake = 0;
         else if (m_sleep == 1 && (src != 0 || low >= 0)) m_wake = 1;
         if (m_irq() == 1 && ack) begin
            m_pend[low] = 0; m_act[low] = 1;
         end else if (eoi) m_act[eoi_id] = 0;
         if (eoi && !(m_irq() == 1 && ack && low == int'(eoi_id))) m_act[eoi_id] = 0;
         for (int k = 0; k < N; k++) if (src[k]) m_pend[k] = 1;
         if (wr_en) m_sleep = wr_sleep ? 1 : 0;
         m_mode = nmode;
         m_child = (m_mode >= 2) ? 1 : 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference.
   always @(negedge clk) begin
      if (rst_n) begin
         int ex_irq;
         ex_irq = m_irq();
         chk({tag, " sleep"}, sleep_o, m_sleep);
         chk({tag, " child"}, child_o, m_child);
         chk({tag, " wake"}, wake_o, m_wake);
         chk({tag, " irq"}, irq_o, ex_irq);
         if (ex_irq == 1) chk({tag, " id"}, id_o, m_lowest());
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin @(posedge clk); #5; end
   endtask

   task automatic wr(input logic v);
      wr_en = 1'b1; wr_sleep = v; tick(); wr_en = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      tag = "R1";
      chk("R1 sleep", sleep_o, 1); chk("R1 child", child_o, 1);
      chk("R1 wake", wake_o, 0);   chk("R1 irq", irq_o, 0);

      tag = "R5";
      src = 8'h08; tick(); src = '0;
      chk("R5 wake set", wake_o, 1);
      tick(3);
      chk("R6 gated", irq_o, 0);
      chk("R5 wake held", wake_o, 1);

      tag = "R2";
      wr(1'b0);
      chk("R2 sleep reads 0", sleep_o, 0);
      chk("R5 wake cleared", wake_o, 0);
      tag = "R3";
      tick(5);
      chk("R3 child held", child_o, 1);
      ready = 1'b1; tick();
      chk("R3 child falls", child_o, 0);
      chk("R6 pending kept", irq_o, 1);
      chk("R6 pending id", id_o, 3);

      tag = "R7";
      src = 8'h22; tick(); src = '0;
      chk("R7 lowest id", id_o, 1);
      tag = "R8";
      ack = 1'b1; tick(); ack = 1'b0;
      chk("R8 next id", id_o, 3);

      tag = "R4";
      wr(1'b1);
      chk("R6 irq low on sleep", irq_o, 0);
      tick(6);
      chk("R4 drain waits", child_o, 0);
      eoi = 1'b1; eoi_id = 3'd1; tick(); eoi = 1'b0;
      tick();
      chk("R4 asleep", child_o, 1);

      tag = "R3";
      wr(1'b0);
      tick(2);
      chk("R3 online", child_o, 0);
      tag = "R9";
      ack = 1'b1; src = 8'h08; tick(); ack = 1'b0; src = '0;
      chk("R9 evt wins", id_o, 3);
      chk("R9 irq", irq_o, 1);

      tag = "R10";
      ack = 1'b1; tick(); ack = 1'b0;
      wr(1'b1); tick(); wr(1'b0);
      tick(4);
      chk("R10 child stays 0", child_o, 0);

      tag = "R4";
      eoi = 1'b1; eoi_id = 3'd3; tick(); eoi_id = 3'd5; tick(); eoi = 1'b0;
      ack = 1'b1; tick(); ack = 1'b0;
      eoi = 1'b1; eoi_id = 3'd5; tick(); eoi = 1'b0;
      wr(1'b1);
      chk("R4 min delay a", child_o, 0);
      tick();
      chk("R4 min delay b", child_o, 0);
      tick();
      chk("R4 min delay c", child_o, 0);
      tick();
      chk("R4 min delay done", child_o, 1);
      tick(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule